// File: doc/BRIEF.md
# Serial Shift Register with Byte Combiner

This block collects a serial bit stream into a 16-bit shift register, one bit per clock, taken from bit 0 of an 8-bit input bus. The register's two byte halves feed an adder and a bitwise AND gate. Each result has its own capture register, loaded by its own strobe bit on the input bus. A 2-bit field on the input bus picks which of four views drives the 8-bit output bus: the low byte, the high byte, the captured sum or the captured AND.

A separate mirror pin overrides the selection and copies the input bus straight to the output bus. The mirror pin changes nothing else. Shifting and capture go on while it is high. No storage is ever cleared: the shift register and both capture registers start at zero at power-up and keep their state from then on. The output bus is registered, so every view appears one clock edge after the inputs and state that produced it.

Top module: `srb_alu`

## Requirements
- R1: On every rising clock edge the shift register moves up one place. Input bit 0 enters at register bit 0 and register bit 15 is dropped.
- R2: The output is registered. With mirror low, select field din[2:1] = 0 shows register bits [7:0] and select = 1 shows register bits [15:8], as they were before the edge that loads the output.
- R3: With mirror low, select = 2 shows the sum capture register and select = 3 shows the AND capture register, as they were before the loading edge.
- R4: When din[4] is high at an edge, the sum capture register loads (low byte + high byte) mod 256. Both bytes are taken from the register contents before that edge, and the carry is discarded.
- R5: When din[5] is high at an edge, the AND capture register loads the bitwise AND of the low and high bytes, taken from the contents before that edge.
- R6: A capture register whose strobe is low at an edge keeps its value.
- R7: If din[4] and din[5] are both high at the same edge, both capture registers load.
- R8: When the mirror pin is high at an edge, the output loads the whole input bus, whatever the select field holds.
- R9: The mirror pin has no other effect. Shifting and captures continue while it is high, and no state is cleared.
- R10: At power-up the output and all four views read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mirror_en | input | 1 | High: the output copies the input bus |
| din | input | 8 | Bit 0 serial data, bits 2:1 view select, bit 4 sum strobe, bit 5 AND strobe |
| dout | output | 8 | Registered output view |

## Verification
The hardest case to reach is the state left after a long stretch in mirror mode. Mirror mode hides every view, while shifting and captures keep running underneath. The bench drives all 256 input values with mirror high, so serial bits and both strobes fire unseen. It then drops mirror and reads out both bytes and both capture registers, comparing them against a model that kept running the whole time. A long pseudo-random sweep covers every mix of select field, strobes and serial data. It also includes cycles where both strobes fire together, and sums that overflow.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    VIEW_LO  = 2'd0,
    VIEW_HI  = 2'd1,
    VIEW_SUM = 2'd2,
    VIEW_AND = 2'd3
  } view_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_AND = 1'b1
  } op_e;

  localparam int SER_BIT = 0;
  localparam int SEL_LSB = 1;
  localparam int ADD_BIT = 4;
  localparam int AND_BIT = 5;
endpackage

// File: rtl/srb_shifter.sv
module srb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         sdi,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int SR_W = 2 * W;

  logic [SR_W-1:0] sr_q = '0;
  logic            armed = 1'b0;

  always_ff @(posedge clk) begin
    sr_q  <= {sr_q[SR_W-2:0], sdi};
    armed <= 1'b1;
  end

  assign lo = sr_q[W-1:0];
  assign hi = sr_q[SR_W-1:W];

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!armed)
    {hi, lo} == {$past(hi[W-2:0]), $past(lo), $past(sdi)});
endmodule

// File: rtl/srb_capture.sv
module srb_capture #(
  parameter int         W  = 8,
  parameter srb_pkg::op_e OP = srb_pkg::OP_ADD
) (
  input  logic         clk,
  input  logic         stb,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q
);
  logic [W-1:0] res;
  logic [W-1:0] q_r = '0;
  logic         armed = 1'b0;

  generate
    if (OP == srb_pkg::OP_ADD) begin : g_add
      assign res = lo + hi;
    end else begin : g_and
      assign res = lo & hi;
    end
  endgenerate

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    if (stb) q_r <= res;
  end

  assign q = q_r;

  // R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    !$past(stb) |-> $stable(q));
endmodule

// File: rtl/srb_view.sv
module srb_view #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         mirror,
  input  logic [W-1:0] din,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] andv,
  output logic [W-1:0] dout
);
  import srb_pkg::*;

  view_e        sel;
  logic [W-1:0] pick;
  logic [W-1:0] out_q = '0;
  logic         armed = 1'b0;

  assign sel = view_e'(din[SEL_LSB +: 2]);

  always_comb begin
    unique case (sel)
      VIEW_LO:  pick = lo;
      VIEW_HI:  pick = hi;
      VIEW_SUM: pick = sum;
      VIEW_AND: pick = andv;
      default:  pick = lo;
    endcase
  end

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    out_q <= mirror ? din : pick;
  end

  assign dout = out_q;

  // R8
  mirror_copy_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(mirror) |-> dout == $past(din));

  // R2
  low_view_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(!mirror) && $past(din[SEL_LSB +: 2]) == 2'd0) |-> dout == $past(lo));

  // R3
  and_view_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(!mirror) && $past(din[SEL_LSB +: 2]) == 2'd3) |-> dout == $past(andv));
endmodule

// File: rtl/srb_alu.sv
module srb_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         mirror_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import srb_pkg::*;

  logic [W-1:0] lo, hi, sum_q, and_q;
  logic         armed = 1'b0;

  initial begin
    if (W < 6) $error("srb_alu needs W >= 6");
  end

  always_ff @(posedge clk) armed <= 1'b1;

  srb_shifter #(.W(W)) shift_i (
    .clk(clk), .sdi(din[SER_BIT]), .lo(lo), .hi(hi)
  );

  srb_capture #(.W(W), .OP(OP_ADD)) sum_i (
    .clk(clk), .stb(din[ADD_BIT]), .lo(lo), .hi(hi), .q(sum_q)
  );

  srb_capture #(.W(W), .OP(OP_AND)) and_i (
    .clk(clk), .stb(din[AND_BIT]), .lo(lo), .hi(hi), .q(and_q)
  );

  srb_view #(.W(W)) view_i (
    .clk(clk), .mirror(mirror_en), .din(din), .lo(lo), .hi(hi),
    .sum(sum_q), .andv(and_q), .dout(dout)
  );

  // R4
  sum_load_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(din[ADD_BIT]) |-> sum_q == W'($past(lo) + $past(hi)));

  // R5
  and_load_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(din[AND_BIT]) |-> and_q == ($past(lo) & $past(hi)));
endmodule

// File: tb/srb_alu_tb_top.sv
`timescale 1ns/1ps
module srb_alu_tb_top;
  logic       clk = 1'b0;
  logic       mirror_en = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_sr  = '0;
  logic [7:0]  m_sum = '0;
  logic [7:0]  m_and = '0;

  always #2.5 clk = ~clk;

  srb_alu #(.W(8)) dut_i (.clk(clk), .mirror_en(mirror_en), .din(din), .dout(dout));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle from a falling edge, advance the model, check at the next falling edge.
  task automatic step(string tag, logic mir, logic [7:0] d);
    logic [7:0] e;
    mirror_en = mir;
    din = d;
    if (mir) e = d;
    else case (d[2:1])
      2'd0: e = m_sr[7:0];
      2'd1: e = m_sr[15:8];
      2'd2: e = m_sum;
      default: e = m_and;
    endcase
    if (d[4]) m_sum = m_sr[7:0] + m_sr[15:8];
    if (d[5]) m_and = m_sr[7:0] & m_sr[15:8];
    m_sr = {m_sr[14:0], d[0]};
    @(posedge clk);
    @(negedge clk);
    chk(tag, dout, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    #1;
    // R10: power-up output, then each view reads zero
    chk("R10", dout, 8'h00);
    for (int s = 0; s < 4; s++) step("R10", 1'b0, 8'(s << 1));

    // R1: shift a known word in, read both bytes
    for (int b = 15; b >= 0; b--) step("R1", 1'b0, {7'd0, 1'(16'hB5C3 >> b)});
    step("R1", 1'b0, 8'h00);
    step("R1", 1'b0, 8'h02);

    // R4: overflowing sum; R6: hold while strobe low
    for (int b = 15; b >= 0; b--) step("R4", 1'b0, {7'd0, 1'(16'hF0A7 >> b)});
    step("R4", 1'b0, 8'h10);
    for (int k = 0; k < 20; k++) step("R6", 1'b0, {5'd0, 2'd2, 1'(k)});
    step("R6", 1'b0, 8'h06);

    // R7: both strobes in the same cycle
    step("R7", 1'b0, 8'h31);
    step("R7", 1'b0, 8'h04);
    step("R7", 1'b0, 8'h06);

    // Pseudo-random sweep over select, strobes and data
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = lfsr[7:0];
      if (i % 13 == 12) step("R8", 1'b1, d);
      else if (d[2:1] == 2'd0 || d[2:1] == 2'd1) step("R2", 1'b0, d);
      else if (d[5] && d[4]) step("R7", 1'b0, d);
      else if (d[2:1] == 2'd2) step("R3/R4", 1'b0, d);
      else step("R3/R5", 1'b0, d);
    end

    // R8: every input value mirrored; R9: hidden state carries on
    for (int v = 0; v < 256; v++) step("R8", 1'b1, 8'(v));
    for (int s = 0; s < 4; s++) step("R9", 1'b0, 8'(s << 1));
    for (int k = 0; k < 16; k++) step("R9", 1'b0, 8'(2 + (k & 1)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule